// File: doc/BRIEF.md
# Bit-Addressable General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port. Each pin has a direction bit and a latched output bit. A direction bit of 1 turns the pin into an output that drives its latched bit; a direction bit of 0 makes the pin an input. Pin levels arriving from outside pass through a two-stage synchronizer before anything can read them. A small register bus reads and writes the direction and latch registers. The port view seen by that bus mixes the synchronized pin levels for input pins with the latched values for output pins.

A bit-operation sequencer sets or clears one bit of the port the way a processor's single-bit instruction does. It reads the whole port view, forces the chosen bit, and writes the full byte back into the output latch. The write-back replaces the whole byte. So the latch bits of input pins are replaced by whatever level those pins had when the port was read, and the stored value they held before is lost. The sequencer reports busy while an operation is in flight. Bus writes that land on the write-back cycle are dropped.

Top module: `gpio_rmw_port`

## Requirements
- R1: After synchronous reset, the direction and output-latch registers are 0, so `pin_oe` and `pin_out` are 0 and `op_busy` is 0.
- R2: `pin_oe` equals the direction register and `pin_out` equals the output latch (direction bit 1 = output, 0 = input).
- R3: Register map, with one cycle of read latency on `bus_rdata`. Address 0 reads the port view and writes the output latch. Address 1 reads and writes the direction register. Address 2 reads the raw output latch. Address 3 reads 0.
- R4: For each bit, the port view returns the synchronized pin level when the direction bit is 0 and the latch bit when it is 1. A pin change reaches `bus_rdata` at the third rising edge after it is applied, never earlier.
- R5: A set operation (`op_code` = 0) reads the port view, forces the selected bit to 1, and writes the full byte into the output latch.
- R6: A clear operation (`op_code` = 1) follows the same sequence but forces the selected bit to 0.
- R7: After an operation, each latch bit of an input pin holds the pin level sampled during the read step, whatever it held before. Example: latch 0x80, direction 0x3F, pins 7/6 low/high; a set of bit 0 reads 0x40 and leaves the latch at 0x41.
- R8: An accepted request raises `op_busy` for exactly three cycles (read, modify, write-back). A request made while busy is ignored.
- R9: A bus write made in the write-back cycle changes neither register, and the latch takes the operation's result.
- R10: The 3-bit `op_bit` selects any bit from 0 to 7, including both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 8 | Registered read data |
| op_valid | input | 1 | Bit-operation request |
| op_code | input | 1 | 0 = set, 1 = clear |
| op_bit | input | 3 | Bit index of the operation |
| op_busy | output | 1 | Operation in flight |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin output enables |

## Verification
The bit operations are run under several mixes of direction and pin pattern. The first mix makes the port view differ from the stored latch, so a stale latch bit is told apart from a sampled pin level. A set and a clear each run on a bit whose old value differs from the target, and both end bits 0 and 7 are used. One operation has a bus write collide with its write-back, and another has a second request arrive while busy, so dropped traffic is told apart from accepted traffic. A pin step watched edge by edge separates a correct two-stage synchronizer from a shorter or longer one.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_READ = 2'd1,
    SEQ_MOD  = 2'd2,
    SEQ_WB   = 2'd3
  } seq_state_e;

  localparam logic OPC_SET = 1'b0;
  localparam logic OPC_CLR = 1'b1;

  localparam int REG_PORT  = 0;
  localparam int REG_DIR   = 1;
  localparam int REG_LATCH = 2;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)              warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  if (STAGES == 2) begin : g_chk
    p_sync_two_r4: assert property (@(posedge clk) disable iff (rst)
      (warm_q == 2'd2) |-> (dout == $past(din, 2)));
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              wb_en,
  input  logic [WIDTH-1:0]  wb_data,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  port_view,
  output logic [WIDTH-1:0]  rdata_q
);
  logic bus_ok;
  assign bus_ok = bus_we && !wb_en;

  for (genvar b = 0; b < WIDTH; b++) begin : g_view
    assign port_view[b] = dir_q[b] ? latch_q[b] : pin_sync[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else if (bus_ok && bus_addr == ADDR_W'(REG_DIR)) begin
      dir_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else if (wb_en) begin
      latch_q <= wb_data;
    end else if (bus_ok && bus_addr == ADDR_W'(REG_PORT)) begin
      latch_q <= bus_wdata;
    end
  end

  logic [WIDTH-1:0] rd_mux;
  always_comb begin
    case (bus_addr)
      ADDR_W'(REG_PORT):  rd_mux = port_view;
      ADDR_W'(REG_DIR):   rd_mux = dir_q;
      ADDR_W'(REG_LATCH): rd_mux = latch_q;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  p_wb_result_r9: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> (latch_q == $past(wb_data)));
  p_wb_dir_hold_r9: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> $stable(dir_q));
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (dir_q == '0 && latch_q == '0));
endmodule

// File: rtl/gpio_bitop_seq.sv
module gpio_bitop_seq
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             op_code,
  input  logic [IDX_W-1:0] op_bit,
  input  logic [WIDTH-1:0] port_view,
  output logic             busy,
  output logic             wb_en,
  output logic [WIDTH-1:0] wb_data
);
  seq_state_e       state_q, state_d;
  logic [WIDTH-1:0] snap_q;
  logic [IDX_W-1:0] bit_q;
  logic             code_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE: if (op_valid) state_d = SEQ_READ;
      SEQ_READ: state_d = SEQ_MOD;
      SEQ_MOD:  state_d = SEQ_WB;
      SEQ_WB:   state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      busy    <= 1'b0;
      bit_q   <= '0;
      code_q  <= OPC_SET;
      snap_q  <= '0;
    end else begin
      state_q <= state_d;
      busy    <= (state_d != SEQ_IDLE);
      if (state_q == SEQ_IDLE && op_valid) begin
        bit_q  <= op_bit;
        code_q <= op_code;
      end
      if (state_q == SEQ_READ) begin
        snap_q <= port_view;
      end else if (state_q == SEQ_MOD) begin
        snap_q[bit_q] <= (code_q == OPC_SET);
      end
    end
  end

  assign wb_en   = (state_q == SEQ_WB);
  assign wb_data = snap_q;

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_IDLE && op_valid) |=> busy);
  p_busy_len_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy ##1 busy ##1 !busy);
  p_bit_forced_r5: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_data[bit_q] == (code_q == OPC_SET)));
  p_wb_once_r8: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> !wb_en);
endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              op_valid,
  input  logic              op_code,
  input  logic [IDX_W-1:0]  op_bit,
  output logic              op_busy,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] port_view;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] latch_q;
  logic             wb_en;
  logic [WIDTH-1:0] wb_data;

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pin_in),
    .dout(pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .wb_en    (wb_en),
    .wb_data  (wb_data),
    .pin_sync (pin_sync),
    .dir_q    (dir_q),
    .latch_q  (latch_q),
    .port_view(port_view),
    .rdata_q  (bus_rdata)
  );

  gpio_bitop_seq #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_bit   (op_bit),
    .port_view(port_view),
    .busy     (op_busy),
    .wb_en    (wb_en),
    .wb_data  (wb_data)
  );

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;

  p_oe_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!op_busy && !bus_we) |=> $stable(pin_oe));
endmodule

// File: tb/gpio_rmw_port_tb_top.sv
module gpio_rmw_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       op_valid = 1'b0;
  logic       op_code = 1'b0;
  logic [2:0] op_bit = '0;
  logic       op_busy;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  always #4 clk = ~clk;

  gpio_rmw_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .op_valid(op_valid),
    .op_code(op_code), .op_bit(op_bit), .op_busy(op_busy),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct {
    int    kind;
    logic [7:0] exp;
    string tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // kind: 0 bus_rdata, 1 pin_out, 2 pin_oe, 3 op_busy
  task automatic expect_next(int kind, logic [7:0] e, string tag);
    exp_item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = bus_rdata;
          1: act = pin_out;
          2: act = pin_oe;
          default: act = {7'b0, op_busy};
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    expect_next(0, e, tag);
    @(negedge clk);
  endtask

  // clash: bus write on write-back cycle; retrig: new request while busy
  task automatic bit_op(logic code, logic [2:0] idx, bit clash, bit retrig);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_bit = idx;
    expect_next(3, 8'h01, "R8 busy after accept");
    @(negedge clk);
    op_valid = 1'b0;
    expect_next(3, 8'h01, "R8 busy read step");
    @(negedge clk);
    if (retrig) begin
      op_valid = 1'b1; op_code = ~code; op_bit = idx ^ 3'd1;
    end
    expect_next(3, 8'h01, "R8 busy modify step");
    @(negedge clk);
    op_valid = 1'b0;
    if (clash) begin
      bus_addr = 2'd0; bus_wdata = 8'h5A; bus_we = 1'b1;
    end
    expect_next(3, 8'h00, "R8 busy drops after write-back");
    @(negedge clk);
    bus_we = 1'b0;
    expect_next(3, 8'h00, "R8 no second op");
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect_next(1, 8'h00, "R1 pin_out");
    expect_next(2, 8'h00, "R1 pin_oe");
    expect_next(3, 8'h00, "R1 busy");
    bus_read(2'd1, 8'h00, "R1 dir reg");
    bus_read(2'd2, 8'h00, "R1 latch reg");
    bus_read(2'd3, 8'h00, "R3 unused address");

    // R4 synchronizer latency, all inputs
    @(negedge clk);
    bus_addr = 2'd0;
    pin_in = 8'h5A;
    expect_next(0, 8'h00, "R4 edge1 old");
    @(negedge clk);
    expect_next(0, 8'h00, "R4 edge2 old");
    @(negedge clk);
    expect_next(0, 8'h5A, "R4 edge3 new");
    @(negedge clk);

    // R7 scenario: latch 0x80, dir 0x3F, pin7 low, pin6 high
    bus_write(2'd0, 8'h80);
    bus_write(2'd1, 8'h3F);
    @(negedge clk);
    pin_in = 8'h40;
    repeat (3) @(negedge clk);
    expect_next(2, 8'h3F, "R2 pin_oe follows dir");
    expect_next(1, 8'h80, "R2 pin_out follows latch");
    bus_read(2'd0, 8'h40, "R3 R4 port view mixes pins and latch");
    bus_read(2'd1, 8'h3F, "R3 dir readback");
    bit_op(1'b0, 3'd0, 1'b0, 1'b0);
    bus_read(2'd2, 8'h41, "R5 R7 set bit0 latch");
    bus_read(2'd0, 8'h41, "R5 port view after set");
    expect_next(1, 8'h41, "R2 pin_out after set");
    @(negedge clk);

    // R6 clear, pins now 0x80: view (0x41&0x3F)|(0x80&0xC0)=0x81 -> 0x80
    pin_in = 8'h80;
    repeat (3) @(negedge clk);
    bit_op(1'b1, 3'd0, 1'b0, 1'b0);
    bus_read(2'd2, 8'h80, "R6 R7 clear bit0 latch");

    // R9 bus write colliding with write-back; view 0x80 -> set bit5 = 0xA0
    bit_op(1'b0, 3'd5, 1'b1, 1'b0);
    bus_read(2'd2, 8'hA0, "R9 write-back wins over bus write");
    bus_read(2'd1, 8'h3F, "R9 dir untouched");

    // R10 top bit and R8 retrigger ignored; all outputs, latch 0
    bus_write(2'd1, 8'hFF);
    bus_write(2'd0, 8'h00);
    bit_op(1'b0, 3'd7, 1'b0, 1'b1);
    bus_read(2'd2, 8'h80, "R10 R8 set bit7 only, retrigger ignored");
    expect_next(1, 8'h80, "R10 pin_out bit7");
    @(negedge clk);

    // R6 clear on output bit that was 1, bit 7
    bit_op(1'b1, 3'd7, 1'b0, 1'b0);
    bus_read(2'd2, 8'h00, "R6 R10 clear bit7");

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hang expected=finish");
    end
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule